// File: doc/BRIEF.md
# Event Timer Register Block

This block is the register front end and main counter of a multi-channel event timer. Software reaches it through a 1 KiB window of 32-bit words, using a single-cycle request port that carries a write flag, a byte address and write data, and returns read data in the same cycle. The block holds a read-only capability word pair, a general configuration register (global run enable and legacy routing select), an interrupt status register, a 64-bit main counter, and, for each implemented timer channel, a configuration word, a 64-bit comparator and a 64-bit route word.

The main counter advances by one on each tick-enable pulse while the global enable is set, and holds its value while it is clear. Turning the global enable on sends a one-cycle arm strobe to every channel whose comparator is not all ones. Turning it off sends a cancel strobe to every channel. Per-channel enable edges and comparator writes produce per-channel arm and cancel strobes too. Comparator matching and interrupt delivery are done by separate channel blocks, which read the stored values from the flattened outputs.

Top module: `evt_regs`

## Requirements
- R1: After reset the counter, general configuration and status read zero. Every comparator reads all ones. Every route word reads zero. Each timer configuration word reads 0x0000_0030, which is its fixed capability bits 4 and 5.
- R2: Offset 0x000 reads {vendor[31:16], bit15=1 legacy capable, bit14=0, bit13=1 64-bit counter, bits12:8 = timers-1, revision[7:0]}; with default parameters this is 0xC0DE_A201. Offset 0x004 reads the tick period in femtoseconds (default 0x0098_9680). Writes to either word have no effect.
- R3: An access whose address bits 1:0 are not zero reads zero and changes no state.
- R4: General configuration at 0x010 keeps only bit 0 (global enable) and bit 1 (legacy). Its other bits read zero. The upper word at 0x014 reads zero and ignores writes.
- R5: While the global enable is set, the counter increases by one in each cycle with tick_i high. While it is clear, the counter holds its value.
- R6: A write to 0x0F0 or 0x0F4 replaces the low or high 32 bits of the counter, and no tick is added in that cycle. Reads of the two words return the live value.
- R7: When the global enable goes from 0 to 1, arm_o pulses for one cycle, in the cycle after the write, for every timer whose comparator is not all ones.
- R8: When the global enable goes from 1 to 0, cancel_o pulses for one cycle on every timer, in the cycle after the write, and the counter freezes.
- R9: Timer n registers sit at 0x100+0x20*n: configuration at +0x0, IRQ capability at +0x4, comparator low and high at +0x8 and +0xC, route low and high at +0x10 and +0x14. Configuration writes keep only the bits in mask 0x0000_7F4E. Bits 4 and 5 always read 1. The +0x4 word reads IRQ_CAP and ignores writes.
- R10: A configuration write that sets bit 2 (timer enable) while the global enable is set pulses that timer's arm_o. A write that clears a set bit 2 pulses its cancel_o. Any comparator write while the global enable is set pulses its arm_o. arm_o and cancel_o never share a set bit.
- R11: Status at 0x020 sets bit n on status_set_i[n]. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R12: Timer indices at or above the implemented count, and undecoded offsets, read zero and ignore writes.
- R13: enable_o and legacy_o follow general configuration bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter tick enable |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 10 | Byte address in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| status_set_i | input | NT | Per-timer status set pulses |
| enable_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy routing select |
| count_o | output | 64 | Main counter |
| tmr_cfg_o | output | NT*32 | Stored per-timer configuration bits |
| tmr_cmp_o | output | NT*64 | Per-timer comparators |
| tmr_route_o | output | NT*64 | Per-timer route words |
| arm_o | output | NT | Per-timer arm strobe |
| cancel_o | output | NT | Per-timer cancel strobe |

## Verification
The assertions assume that at most one access arrives per cycle. They also assume that the address is held only while req_i is high, and that tick_i is a level sampled on each edge. The counter-step property does not hold in a cycle that writes the counter, so it excludes those cycles. The bench issues each access in its own cycle with idle cycles between accesses, and drives tick_i in a fixed repeating pattern. It places counter writes both in frozen and in running periods, so that both the write-wins rule and the carry across the 32-bit boundary are exercised.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] OFF_CAP_LO  = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI  = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_GCFG    = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_STAT    = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 10'h0F4;
  localparam logic [4:0] TO_CFG    = 5'h00;
  localparam logic [4:0] TO_CAP    = 5'h04;
  localparam logic [4:0] TO_CMP_LO = 5'h08;
  localparam logic [4:0] TO_CMP_HI = 5'h0C;
  localparam logic [4:0] TO_RT_LO  = 5'h10;
  localparam logic [4:0] TO_RT_HI  = 5'h14;
  localparam logic [31:0] TCFG_WMASK = 32'h0000_7F4E;
  localparam logic [31:0] TCFG_FIXED = 32'h0000_0030;
  localparam int TCFG_EN_BIT = 2;

  function automatic int clamp_timers(input int n);
    return (n < 3) ? 3 : ((n > 32) ? 32 : n);
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int HI_W = CNT_W - 32;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_lo_i) cnt_q[31:0] <= wdata_i;
    else if (wr_hi_i) cnt_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_lo_i && !wr_hi_i) |=> cnt_o == $past(cnt_o) + CNT_W'($past(tick_i)));
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int NT = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [4:0]     idx_i,
  input  logic [4:0]     off_i,
  input  logic [31:0]    wdata_i,
  input  logic           gen_en_i,
  input  logic           gen_rise_i,
  input  logic           gen_fall_i,
  output logic [NT*32-1:0] cfg_o,
  output logic [NT*64-1:0] cmp_o,
  output logic [NT*64-1:0] route_o,
  output logic [NT-1:0]  arm_o,
  output logic [NT-1:0]  cancel_o
);
  for (genvar g = 0; g < NT; g++) begin : g_tmr
    logic [31:0] cfg_q;
    logic [63:0] cmp_q, rt_q;
    logic        arm_q, can_q;
    logic        sel;
    assign sel = wr_i && (idx_i == 5'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
        cmp_q <= '1;
        rt_q  <= '0;
        arm_q <= 1'b0;
        can_q <= 1'b0;
      end else begin
        arm_q <= gen_rise_i && !(&cmp_q);
        can_q <= gen_fall_i;
        if (sel) begin
          case (off_i)
            TO_CFG: begin
              cfg_q <= wdata_i & TCFG_WMASK;
              if (wdata_i[TCFG_EN_BIT] && !cfg_q[TCFG_EN_BIT] && gen_en_i) arm_q <= 1'b1;
              if (!wdata_i[TCFG_EN_BIT] && cfg_q[TCFG_EN_BIT]) can_q <= 1'b1;
            end
            TO_CMP_LO: begin
              cmp_q[31:0] <= wdata_i;
              arm_q <= gen_en_i;
            end
            TO_CMP_HI: begin
              cmp_q[63:32] <= wdata_i;
              arm_q <= gen_en_i;
            end
            TO_RT_LO: rt_q[31:0]  <= wdata_i;
            TO_RT_HI: rt_q[63:32] <= wdata_i;
            default: ;
          endcase
        end
      end
    end

    assign cfg_o[g*32 +: 32]   = cfg_q;
    assign cmp_o[g*64 +: 64]   = cmp_q;
    assign route_o[g*64 +: 64] = rt_q;
    assign arm_o[g]            = arm_q;
    assign cancel_o[g]         = can_q;
  end

  a_r10_arm_cancel_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_o & cancel_o) == '0);
  a_r7_arm_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arm_o) |-> gen_en_i);
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [31:0] PERIOD_FS  = 32'd10_000_000,
  parameter logic [31:0] IRQ_CAP    = 32'h00F0_0000,
  localparam int         NT         = clamp_timers(NUM_TIMERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [9:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NT-1:0]     status_set_i,
  output logic              enable_o,
  output logic              legacy_o,
  output logic [63:0]       count_o,
  output logic [NT*32-1:0]  tmr_cfg_o,
  output logic [NT*64-1:0]  tmr_cmp_o,
  output logic [NT*64-1:0]  tmr_route_o,
  output logic [NT-1:0]     arm_o,
  output logic [NT-1:0]     cancel_o
);
  localparam logic [31:0] CAP_LO = {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NT-1), REV_ID};

  logic          acc, wr, tmr_sel, t_ok;
  logic [4:0]    tidx, toff;
  logic          en_q, leg_q, gcfg_wr, gen_rise, gen_fall;
  logic [NT-1:0] stat_q;

  assign acc     = req_i && (addr_i[1:0] == 2'b00);
  assign wr      = acc && we_i;
  assign tmr_sel = |addr_i[9:8];
  assign tidx    = addr_i[9:5] - 5'd8;
  assign toff    = addr_i[4:0];
  assign t_ok    = tmr_sel && (int'(tidx) < NT);

  assign gcfg_wr  = wr && (addr_i == OFF_GCFG);
  assign gen_rise = gcfg_wr && wdata_i[0] && !en_q;
  assign gen_fall = gcfg_wr && !wdata_i[0] && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      leg_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (gcfg_wr) begin
        en_q  <= wdata_i[0];
        leg_q <= wdata_i[1];
      end
      stat_q <= (stat_q & ~((wr && addr_i == OFF_STAT) ? wdata_i[NT-1:0] : '0)) | status_set_i;
    end
  end

  evt_counter #(.CNT_W(64)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .tick_i  (tick_i),
    .wr_lo_i (wr && addr_i == OFF_CNT_LO),
    .wr_hi_i (wr && addr_i == OFF_CNT_HI),
    .wdata_i (wdata_i),
    .cnt_o   (count_o)
  );

  evt_timer_regs #(.NT(NT)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr && t_ok),
    .idx_i      (tidx),
    .off_i      (toff),
    .wdata_i    (wdata_i),
    .gen_en_i   (en_q),
    .gen_rise_i (gen_rise),
    .gen_fall_i (gen_fall),
    .cfg_o      (tmr_cfg_o),
    .cmp_o      (tmr_cmp_o),
    .route_o    (tmr_route_o),
    .arm_o      (arm_o),
    .cancel_o   (cancel_o)
  );

  always_comb begin
    rdata_o = '0;
    if (acc && !we_i) begin
      if (tmr_sel) begin
        if (t_ok) begin
          case (toff)
            TO_CFG:    rdata_o = tmr_cfg_o[tidx*32 +: 32] | TCFG_FIXED;
            TO_CAP:    rdata_o = IRQ_CAP;
            TO_CMP_LO: rdata_o = tmr_cmp_o[tidx*64 +: 32];
            TO_CMP_HI: rdata_o = tmr_cmp_o[tidx*64+32 +: 32];
            TO_RT_LO:  rdata_o = tmr_route_o[tidx*64 +: 32];
            TO_RT_HI:  rdata_o = tmr_route_o[tidx*64+32 +: 32];
            default:   rdata_o = '0;
          endcase
        end
      end else begin
        case (addr_i)
          OFF_CAP_LO: rdata_o = CAP_LO;
          OFF_CAP_HI: rdata_o = PERIOD_FS;
          OFF_GCFG:   rdata_o = {30'd0, leg_q, en_q};
          OFF_STAT:   rdata_o = 32'(stat_q);
          OFF_CNT_LO: rdata_o = count_o[31:0];
          OFF_CNT_HI: rdata_o = count_o[63:32];
          default:    rdata_o = '0;
        endcase
      end
    end
  end

  assign enable_o = en_q;
  assign legacy_o = leg_q;

  a_r8_fall_cancels_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enable_o) |-> (&cancel_o));
  a_r3_unaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |-> rdata_o == '0);
  a_r12_out_of_range_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && tmr_sel && !t_ok) |-> rdata_o == '0);
  a_r3_unaligned_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[1:0] != 2'b00) |=> $stable(enable_o) && $stable(legacy_o));
endmodule

// File: tb/evt_regs_test.sv
module evt_regs_test;
  localparam int NT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NT-1:0] sset = '0;
  logic en_o, leg_o;
  logic [63:0] cnt_o;
  logic [NT*32-1:0] cfg_o;
  logic [NT*64-1:0] cmp_o, rt_o;
  logic [NT-1:0] arm, cancel;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_regs #(.NUM_TIMERS(NT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .status_set_i(sset),
    .enable_o(en_o), .legacy_o(leg_o), .count_o(cnt_o), .tmr_cfg_o(cfg_o),
    .tmr_cmp_o(cmp_o), .tmr_route_o(rt_o), .arm_o(arm), .cancel_o(cancel));

  // reference model
  logic [63:0] m_cnt;
  logic m_en, m_leg;
  logic [63:0] m_cmp [NT];
  logic m_te [NT];
  logic [NT-1:0] m_arm, m_cancel;

  always @(posedge clk or negedge rst_n) begin : model
    logic [NT-1:0] a, c;
    int idx, off;
    if (!rst_n) begin
      m_cnt <= '0; m_en <= 0; m_leg <= 0; m_arm <= '0; m_cancel <= '0;
      for (int i = 0; i < NT; i++) begin m_cmp[i] <= '1; m_te[i] <= 0; end
    end else begin
      a = '0; c = '0;
      if (req && we && addr[1:0] == 0) begin
        if (addr == 10'h010) begin
          if (wdata[0] && !m_en)
            for (int i = 0; i < NT; i++) a[i] = (m_cmp[i] != 64'hFFFF_FFFF_FFFF_FFFF);
          if (!wdata[0] && m_en) c = '1;
          m_en <= wdata[0]; m_leg <= wdata[1];
        end
        if (addr >= 10'h100) begin
          idx = (int'(addr) - 'h100) >> 5;
          off = int'(addr) & 'h1f;
          if (idx < NT) begin
            if (off == 0) begin
              if (wdata[2] && !m_te[idx] && m_en) a[idx] = 1;
              if (!wdata[2] && m_te[idx]) c[idx] = 1;
              m_te[idx] <= wdata[2];
            end else if (off == 8) begin
              m_cmp[idx][31:0] <= wdata; if (m_en) a[idx] = 1;
            end else if (off == 'hC) begin
              m_cmp[idx][63:32] <= wdata; if (m_en) a[idx] = 1;
            end
          end
        end
      end
      if (req && we && addr == 10'h0F0) m_cnt[31:0] <= wdata;
      else if (req && we && addr == 10'h0F4) m_cnt[63:32] <= wdata;
      else if (m_en && tick) m_cnt <= m_cnt + 1;
      m_arm <= a; m_cancel <= c;
    end
  end

  // per-cycle compare: R5 R7 R8 R10 R13
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      total++;
      if (cnt_o !== m_cnt || arm !== m_arm || cancel !== m_cancel || en_o !== m_en || leg_o !== m_leg) begin
        bad++;
        $display("FAIL R5/R7/R8/R10/R13 cycle %0d: cnt=%h/%h arm=%b/%b cancel=%b/%b en=%b/%b leg=%b/%b",
                 cyc, cnt_o, m_cnt, arm, m_arm, cancel, m_cancel, en_o, m_en, leg_o, m_leg);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 3 != 0);
  end

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 chk(64'(rdata), 64'(exp), tag);
    @(posedge clk); #1 req = 0;
  endtask

  task automatic rd_cnt(input logic hi, input string tag);
    @(negedge clk); req = 1; we = 0; addr = hi ? 10'h0F4 : 10'h0F0;
    #1 chk(64'(rdata), hi ? 64'(m_cnt[63:32]) : 64'(m_cnt[31:0]), tag);
    @(posedge clk); #1 req = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(10'h010, 32'h0, "R1 gcfg");
    rd(10'h020, 32'h0, "R1 status");
    rd(10'h0F0, 32'h0, "R1 cnt lo");
    rd(10'h100, 32'h30, "R1 t0 cfg");
    rd(10'h148, 32'hFFFF_FFFF, "R1 t2 cmp lo");
    rd(10'h12C, 32'hFFFF_FFFF, "R1 t1 cmp hi");
    rd(10'h150, 32'h0, "R1 t2 route");
    // R2 capability
    rd(10'h000, 32'hC0DE_A201, "R2 cap lo");
    rd(10'h004, 32'h0098_9680, "R2 cap hi");
    wr(10'h000, 32'h0); wr(10'h004, 32'h1);
    rd(10'h000, 32'hC0DE_A201, "R2 cap lo after write");
    rd(10'h004, 32'h0098_9680, "R2 cap hi after write");
    // R4 masks
    wr(10'h010, 32'hFFFF_FFFC);
    rd(10'h010, 32'h0, "R4 gcfg mask");
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, 32'h0, "R4 gcfg hi");
    // R3 unaligned
    wr(10'h011, 32'h1);
    chk(64'(en_o), 64'd0, "R3 unaligned write ignored");
    rd(10'h011, 32'h0, "R3 unaligned read");
    wr(10'h10A, 32'h55);
    rd(10'h108, 32'hFFFF_FFFF, "R3 unaligned cmp write ignored");
    // R6 counter write while frozen, R5 frozen
    wr(10'h0F0, 32'h0000_1234);
    wr(10'h0F4, 32'h0000_0005);
    repeat (5) @(posedge clk);
    rd(10'h0F0, 32'h0000_1234, "R5 frozen lo");
    rd(10'h0F4, 32'h0000_0005, "R6 hi");
    // comparators while disabled: no arm
    wr(10'h108, 32'h100); wr(10'h10C, 32'h0);
    chk(64'(arm), 64'd0, "R10 no arm when disabled");
    wr(10'h148, 32'h5);
    rd(10'h148, 32'h5, "R9 t2 cmp lo");
    wr(10'h150, 32'hA5A5_0001); wr(10'h154, 32'h0000_00FE);
    rd(10'h154, 32'h0000_00FE, "R9 t2 route hi");
    // R7 global enable rise
    wr(10'h010, 32'h3);
    chk(64'(arm), 64'b101, "R7 arm set");
    chk(64'(leg_o), 64'd1, "R13 legacy");
    repeat (6) @(posedge clk);
    rd_cnt(0, "R5 running lo");
    // R9 / R10 timer config
    wr(10'h120, 32'h4);
    chk(64'(arm), 64'b010, "R10 timer enable arm");
    rd(10'h120, 32'h34, "R9 t1 cfg");
    wr(10'h120, 32'hFFFF_FFFF);
    rd(10'h120, 32'h0000_7F7E, "R9 cfg mask");
    rd(10'h124, 32'h00F0_0000, "R9 irq cap");
    wr(10'h124, 32'h0);
    rd(10'h124, 32'h00F0_0000, "R9 irq cap ignores write");
    wr(10'h120, 32'h0);
    chk(64'(cancel), 64'b010, "R10 timer disable cancel");
    wr(10'h108, 32'h200);
    chk(64'(arm), 64'b001, "R10 cmp write arm");
    // R11 status
    @(negedge clk); sset = 3'b110;
    @(negedge clk); sset = 3'b000;
    rd(10'h020, 32'h6, "R11 status set");
    wr(10'h020, 32'h2);
    rd(10'h020, 32'h4, "R11 w1c");
    wr(10'h020, 32'h1);
    rd(10'h020, 32'h4, "R11 write 0 keeps");
    @(negedge clk); req = 1; we = 1; addr = 10'h020; wdata = 32'h4; sset = 3'b100;
    @(posedge clk); #1 req = 0; we = 0; sset = 3'b000;
    rd(10'h020, 32'h4, "R11 set wins");
    // R12 out of range and undecoded
    wr(10'h168, 32'h0);
    rd(10'h168, 32'h0, "R12 t3 cmp");
    rd(10'h160, 32'h0, "R12 t3 cfg");
    wr(10'h388, 32'h0);
    rd(10'h388, 32'h0, "R12 t20 cmp");
    rd(10'h040, 32'h0, "R12 undecoded");
    rd(10'h108, 32'h200, "R12 t0 untouched");
    // R6 counter write while running, carry
    wr(10'h0F4, 32'h0);
    wr(10'h0F0, 32'hFFFF_FFFF);
    repeat (4) @(posedge clk);
    rd_cnt(1, "R6 carry hi");
    // R8 disable
    wr(10'h010, 32'h0);
    chk(64'(cancel), 64'b111, "R8 cancel all");
    chk(64'(en_o), 64'd0, "R13 enable clear");
    repeat (5) @(posedge clk);
    rd_cnt(0, "R8 frozen lo");
    rd_cnt(1, "R8 frozen hi");
    // R7 rise with all comparators reset to all ones except written ones
    wr(10'h108, 32'hFFFF_FFFF); wr(10'h10C, 32'hFFFF_FFFF);
    wr(10'h010, 32'h1);
    chk(64'(arm), 64'b100, "R7 skip all-ones cmp");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule